// File: doc/BRIEF.md
# Hart-Private Store Buffer with Load Forwarding

This block sits between one hart's commit stage and its memory write port. Committed stores enter a small in-order queue. Each entry holds a word address, a byte mask, the data word and a flag that marks it as the result of an atomic memory operation or a store-conditional. Entries leave the queue strictly oldest first, through a ready/valid drain port. Younger loads from the same hart look the queue up on every request, so a load sees its own hart's pending writes before those writes reach memory.

A load picks up each requested byte from the youngest queued store that writes that byte. Any byte that no queued store covers is read from memory through a one-cycle synchronous read port. Forwarding is refused in some cases, and the load is then held back (load ready low) instead of reading a stale value: the overlapping store is atomic-flagged, its data is not yet known, or some queued store still has an unknown address. A store's address or data may arrive after the store is enqueued. The enqueue port reports the slot each store lands in, and a separate fix-up port fills in the missing field later.

Addresses are word addresses. Byte lane b of any data word is bits 8b+7..8b and is enabled by mask bit b. A misaligned access is presented as separate word accesses, and overlap is judged byte by byte.

Top module: `store_buffer_fwd`

## Requirements
- R1: After reset the buffer is empty: enq_ready is 1, dr_valid is 0, ld_rsp_valid is 0 and ld_ready is 1.
- R2: A load accepted while ld_valid and ld_ready are both high gives ld_rsp_valid one cycle later. Every requested byte written by a queued store takes that store's data, even when memory still holds the old value.
- R3: Requested bytes covered by no queued store are returned from memory. Byte lanes outside the load mask read as zero in ld_rsp_data.
- R4: When several queued stores to the load's address write the same byte, that byte comes from the youngest of them, chosen separately for each byte.
- R5: A load whose requested bytes overlap an atomic-flagged entry keeps ld_ready low until that entry has drained, and then reads the drained value from memory. Loads that overlap no such entry are not held back.
- R6: While any queued store has an unresolved address, every load is held (ld_ready low) and that store does not drain. A load that overlaps a store with unresolved data is held until the data is supplied.
- R7: enq_slot names the slot the next enqueued store will occupy. A fix-up to a live slot fills in its address and/or data only while that field is still unresolved.
- R8: With DEPTH entries queued, enq_ready is 0 and an enqueue attempt is dropped without effect.
- R9: Entries drain in enqueue order, one beat per queued store, with no merging of stores to the same address. While dr_ready is low, dr_addr, dr_mask and dr_data stay stable.
- R10: A store whose data equals the current memory contents still produces its own drain beat.
- R11: A store enqueued in the same cycle that a load is accepted counts as younger than that load and is not forwarded to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Store enqueue request |
| enq_ready | output | 1 | Buffer has a free slot |
| enq_addr | input | AW | Store word address |
| enq_addr_ok | input | 1 | Store address is resolved |
| enq_mask | input | DW/8 | Store byte enables |
| enq_data | input | DW | Store data |
| enq_data_ok | input | 1 | Store data is resolved |
| enq_atomic | input | 1 | Store comes from an atomic or store-conditional |
| enq_slot | output | log2(DEPTH) | Slot taken by the next enqueue |
| fix_valid | input | 1 | Fix-up request |
| fix_slot | input | log2(DEPTH) | Slot to fix up |
| fix_addr_en | input | 1 | Supply the address |
| fix_addr | input | AW | Resolved address |
| fix_data_en | input | 1 | Supply the data |
| fix_data | input | DW | Resolved data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load may be accepted this cycle |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte enables |
| ld_rsp_valid | output | 1 | Load response valid |
| ld_rsp_data | output | DW | Load response data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, one cycle after the strobe |
| dr_valid | output | 1 | Oldest entry is ready to drain |
| dr_ready | input | 1 | Memory accepts the drain beat |
| dr_addr | output | AW | Drain address |
| dr_mask | output | DW/8 | Drain byte enables |
| dr_data | output | DW | Drain data |

## Verification
A wrong head or tail pointer shows on the drain port within a few beats, as a store drained out of order, repeated or lost. The bench therefore logs every drain beat and compares the log against the enqueue sequence. A wrong per-byte youngest-match selection shows on the very next load response as one wrong lane, so the forwarding tests stack overlapping masks and check each lane. Missing hazard conditions for atomic or unresolved entries show at once as ld_ready high in a cycle where it must be low. The bench probes ld_ready directly before it allows any drain.

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  output logic                       enq_ready,
  input  logic [AW-1:0]              enq_addr,
  input  logic                       enq_addr_ok,
  input  logic [DW/8-1:0]            enq_mask,
  input  logic [DW-1:0]              enq_data,
  input  logic                       enq_data_ok,
  input  logic                       enq_atomic,
  output logic [$clog2(DEPTH)-1:0]   enq_slot,
  input  logic                       fix_valid,
  input  logic [$clog2(DEPTH)-1:0]   fix_slot,
  input  logic                       fix_addr_en,
  input  logic [AW-1:0]              fix_addr,
  input  logic                       fix_data_en,
  input  logic [DW-1:0]              fix_data,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic [AW-1:0]              ld_addr,
  input  logic [DW/8-1:0]            ld_mask,
  output logic                       ld_rsp_valid,
  output logic [DW-1:0]              ld_rsp_data,
  output logic                       mem_rd_en,
  output logic [AW-1:0]              mem_rd_addr,
  input  logic [DW-1:0]              mem_rd_data,
  output logic                       dr_valid,
  input  logic                       dr_ready,
  output logic [AW-1:0]              dr_addr,
  output logic [DW/8-1:0]            dr_mask,
  output logic [DW-1:0]              dr_data
);
  localparam int NB = DW / 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] e_addr [DEPTH];
  logic [NB-1:0] e_mask [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [DEPTH-1:0] e_aok, e_dok, e_atom;

  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  logic          hazard;
  logic [NB-1:0] fwd_m;
  logic [DW-1:0] fwd_d;

  logic          rsp_v;
  logic [NB-1:0] rsp_fm, rsp_lm;
  logic [DW-1:0] rsp_fd;

  logic enq_fire, drain_fire, ld_fire, fix_live;

  assign enq_ready  = (count != CW'(DEPTH));
  assign enq_fire   = enq_valid && enq_ready;
  assign enq_slot   = tail;
  assign dr_valid   = (count != '0) && e_aok[head] && e_dok[head];
  assign drain_fire = dr_valid && dr_ready;
  assign dr_addr    = e_addr[head];
  assign dr_mask    = e_mask[head];
  assign dr_data    = e_data[head];
  assign ld_ready   = !hazard;
  assign ld_fire    = ld_valid && ld_ready;
  assign mem_rd_en  = ld_fire;
  assign mem_rd_addr = ld_addr;
  assign fix_live   = fix_valid && (CW'(PW'(fix_slot - head)) < count);
  assign ld_rsp_valid = rsp_v;

  always_comb begin
    hazard = 1'b0;
    fwd_m  = '0;
    fwd_d  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(k);
      if (CW'(k) < count) begin
        if (!e_aok[idx]) begin
          hazard = 1'b1;
        end else if (e_addr[idx] == ld_addr) begin
          for (int b = 0; b < NB; b++) begin
            if (e_mask[idx][b] && ld_mask[b]) begin
              if (e_atom[idx] || !e_dok[idx]) hazard = 1'b1;
              fwd_m[b]          = 1'b1;
              fwd_d[b*8 +: 8]   = e_data[idx][b*8 +: 8];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      rsp_v <= 1'b0;
    end else begin
      rsp_v <= ld_fire;
      if (enq_fire)   tail <= tail + 1'b1;
      if (drain_fire) head <= head + 1'b1;
      unique case ({enq_fire, drain_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      e_addr[tail] <= enq_addr;
      e_mask[tail] <= enq_mask;
      e_data[tail] <= enq_data;
      e_aok[tail]  <= enq_addr_ok;
      e_dok[tail]  <= enq_data_ok;
      e_atom[tail] <= enq_atomic;
    end
    if (fix_live) begin
      if (fix_addr_en && !e_aok[fix_slot]) begin
        e_addr[fix_slot] <= fix_addr;
        e_aok[fix_slot]  <= 1'b1;
      end
      if (fix_data_en && !e_dok[fix_slot]) begin
        e_data[fix_slot] <= fix_data;
        e_dok[fix_slot]  <= 1'b1;
      end
    end
    if (ld_fire) begin
      rsp_fm <= fwd_m;
      rsp_fd <= fwd_d;
      rsp_lm <= ld_mask;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign ld_rsp_data[b*8 +: 8] = !rsp_lm[b] ? 8'h00 :
                                   rsp_fm[b]  ? rsp_fd[b*8 +: 8] : mem_rd_data[b*8 +: 8];
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_refuse_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && !enq_ready && !drain_fire |=> count == $past(count));

  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_mask) && $stable(dr_data));

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |=> ld_rsp_valid);

  p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid |-> $past(mem_rd_en));

endmodule

// File: tb/store_buffer_fwd_test.sv
module store_buffer_fwd_test;
  localparam int AW = 32, DW = 32, DEPTH = 4, PW = 2;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          enq_valid = 0, enq_ready, enq_addr_ok = 1, enq_data_ok = 1, enq_atomic = 0;
  logic [AW-1:0] enq_addr = '0;
  logic [3:0]    enq_mask = '0;
  logic [DW-1:0] enq_data = '0;
  logic [PW-1:0] enq_slot, fix_slot = '0;
  logic          fix_valid = 0, fix_addr_en = 0, fix_data_en = 0;
  logic [AW-1:0] fix_addr = '0;
  logic [DW-1:0] fix_data = '0;
  logic          ld_valid = 0, ld_ready, ld_rsp_valid;
  logic [AW-1:0] ld_addr = '0;
  logic [3:0]    ld_mask = '0;
  logic [DW-1:0] ld_rsp_data;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          dr_valid, dr_ready = 0;
  logic [AW-1:0] dr_addr;
  logic [3:0]    dr_mask;
  logic [DW-1:0] dr_data;

  store_buffer_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (.*);

  logic [DW-1:0] mem [16];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int n_log = 0, checks = 0, errors = 0;

  always @(posedge clk) begin
    if (dr_valid && dr_ready) begin
      for (int b = 0; b < 4; b++)
        if (dr_mask[b]) mem[dr_addr[3:0]][b*8 +: 8] <= dr_data[b*8 +: 8];
      log_addr[n_log] <= dr_addr;
      log_data[n_log] <= dr_data;
      n_log <= n_log + 1;
    end
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[3:0]];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic enq(input logic [31:0] a, input logic [3:0] m, input logic [31:0] d,
                     input logic aok, input logic dok, input logic atom, output logic [PW-1:0] slot);
    @(negedge clk);
    enq_addr = a; enq_mask = m; enq_data = d;
    enq_addr_ok = aok; enq_data_ok = dok; enq_atomic = atom; enq_valid = 1;
    #1 slot = enq_slot;
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic load(input logic [31:0] a, input logic [3:0] m, output logic [31:0] d);
    int guard = 0;
    @(negedge clk);
    ld_addr = a; ld_mask = m; ld_valid = 1;
    #1;
    while (!ld_ready && guard < 200) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    ld_valid = 0;
    d = ld_rsp_valid ? ld_rsp_data : 32'hxxxxxxxx;
  endtask

  task automatic probe(input logic [31:0] a, input logic [3:0] m, output logic r);
    @(negedge clk);
    ld_addr = a; ld_mask = m;
    #1 r = ld_ready;
  endtask

  task automatic fix(input logic [PW-1:0] s, input logic ae, input logic [31:0] a,
                     input logic de, input logic [31:0] d);
    @(negedge clk);
    fix_valid = 1; fix_slot = s; fix_addr_en = ae; fix_addr = a; fix_data_en = de; fix_data = d;
    @(negedge clk);
    fix_valid = 0; fix_addr_en = 0; fix_data_en = 0;
  endtask

  task automatic flush;
    int guard = 0;
    dr_ready = 1;
    @(negedge clk);
    while (dr_valid && guard < 100) begin @(negedge clk); guard++; end
    dr_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 enq_ready", enq_ready, 1);
    check("R1 dr_valid", dr_valid, 0);
    check("R1 ld_rsp_valid", ld_rsp_valid, 0);
    check("R1 ld_ready", ld_ready, 1);
  endtask

  task automatic t_full_forward;
    logic [PW-1:0] s; logic [31:0] d;
    enq(3, 4'hF, 32'hDEADBEEF, 1, 1, 0, s);
    load(3, 4'hF, d);
    check("R2 forward whole word", d, 32'hDEADBEEF);
    check("R2 memory not yet written", mem[3], 32'h04040404);
    flush();
    check("R9 drained to memory", mem[3], 32'hDEADBEEF);
  endtask

  task automatic t_partial;
    logic [PW-1:0] s; logic [31:0] d;
    enq(5, 4'b0011, 32'h00001234, 1, 1, 0, s);
    load(5, 4'hF, d);
    check("R3 merge with memory", d, 32'h06061234);
    load(5, 4'b0110, d);
    check("R3 unrequested lanes zero", d, 32'h00061200);
    flush();
  endtask

  task automatic t_youngest;
    logic [PW-1:0] s; logic [31:0] d;
    enq(6, 4'hF, 32'hAAAAAAAA, 1, 1, 0, s);
    enq(6, 4'b0101, 32'h00BB00BB, 1, 1, 0, s);
    enq(7, 4'hF, 32'hCCCCCCCC, 1, 1, 0, s);
    load(6, 4'hF, d);
    check("R4 youngest per byte", d, 32'hAABBAABB);
    flush();
  endtask

  task automatic t_atomic;
    logic [PW-1:0] s; logic [31:0] d; logic r;
    enq(8, 4'hF, 32'h12345678, 1, 1, 1, s);
    probe(8, 4'b0001, r);
    check("R5 overlapping load held", r, 0);
    repeat (3) @(negedge clk);
    probe(8, 4'b1000, r);
    check("R5 still held without drain", r, 0);
    probe(9, 4'hF, r);
    check("R5 other address not held", r, 1);
    flush();
    load(8, 4'hF, d);
    check("R5 value from memory after drain", d, 32'h12345678);
  endtask

  task automatic t_unresolved;
    logic [PW-1:0] s; logic [31:0] d; logic r;
    enq(10, 4'hF, 32'h55667788, 0, 1, 0, s);
    probe(1, 4'hF, r);
    check("R6 unknown address holds all loads", r, 0);
    dr_ready = 1;
    repeat (2) @(negedge clk);
    check("R6 unknown address not drained", dr_valid, 0);
    dr_ready = 0;
    fix(s, 1, 10, 0, 32'h0);
    probe(1, 4'hF, r);
    check("R7 address fix releases loads", r, 1);
    load(10, 4'hF, d);
    check("R7 forward after address fix", d, 32'h55667788);
    flush();
    enq(11, 4'hF, 32'h0, 1, 0, 0, s);
    probe(11, 4'b0100, r);
    check("R6 unknown data holds overlap", r, 0);
    probe(12, 4'hF, r);
    check("R6 unknown data spares others", r, 1);
    fix(s, 0, 0, 1, 32'h99AABBCC);
    fix(s, 0, 0, 1, 32'h11111111);
    load(11, 4'hF, d);
    check("R7 forward after data fix", d, 32'h99AABBCC);
    flush();
    check("R7 drained fixed data", mem[11], 32'h99AABBCC);
  endtask

  task automatic t_capacity;
    logic [PW-1:0] s; int base;
    base = n_log;
    enq(12, 4'hF, 32'h1, 1, 1, 0, s);
    enq(12, 4'hF, 32'h2, 1, 1, 0, s);
    enq(13, 4'hF, 32'h3, 1, 1, 0, s);
    enq(12, 4'b0001, 32'h4, 1, 1, 0, s);
    check("R8 full refuses", enq_ready, 0);
    enq(14, 4'hF, 32'h5, 1, 1, 0, s);
    check("R9 head held data", dr_data, 32'h1);
    @(negedge clk);
    check("R9 head stable while stalled", dr_data, 32'h1);
    flush();
    check("R8 beat count", n_log - base, 4);
    check("R9 order 0", log_data[base], 32'h1);
    check("R9 order 1", log_data[base+1], 32'h2);
    check("R9 order 2 addr", log_addr[base+2], 32'd13);
    check("R9 order 3", log_data[base+3], 32'h4);
    check("R8 dropped store absent", mem[14], 32'h0F0F0F0F);
  endtask

  task automatic t_silent;
    logic [PW-1:0] s; int base;
    base = n_log;
    enq(15, 4'hF, 32'h10101010, 1, 1, 0, s);
    flush();
    check("R10 silent store drained", n_log - base, 1);
    check("R10 silent store data", log_data[base], 32'h10101010);
  endtask

  task automatic t_same_cycle;
    logic [PW-1:0] s; logic [31:0] d;
    @(negedge clk);
    enq_addr = 2; enq_mask = 4'hF; enq_data = 32'h77777777;
    enq_addr_ok = 1; enq_data_ok = 1; enq_atomic = 0; enq_valid = 1;
    ld_addr = 2; ld_mask = 4'hF; ld_valid = 1;
    @(negedge clk);
    enq_valid = 0; ld_valid = 0;
    check("R11 same-cycle store not forwarded", ld_rsp_data, 32'h03030303);
    load(2, 4'hF, d);
    check("R11 later load forwarded", d, 32'h77777777);
    flush();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h01010101 * (i + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_forward();
    t_partial();
    t_youngest();
    t_atomic();
    t_unresolved();
    t_capacity();
    t_silent();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule